// File: doc/BRIEF.md
# Context-Driven Reconfigurable Processing Cell

This block is one coarse-grain compute cell for a two-dimensional array. A 32-bit context word, presented on each clock cycle, sets everything the cell does in that cycle. It picks two 16-bit operands through two source selectors, runs one arithmetic function, passes the result through a 32-bit barrel shifter, and sends the shifted value to its destinations. Operand sources are the four nearest neighbours, the other cells of the same quadrant row and column, a 16-bit operand-bus segment and a local four-entry register file.

The shifted result is always loaded into a 32-bit accumulator register, which is also fed back into the function unit. The context word can also send the low half of the result into a chosen register-file entry and onto an express-lane output. The function unit does pass, add, subtract, add-immediate, multiply, single-cycle multiply-accumulate, absolute-difference accumulate and a ones count. A static mode input chooses signed (two's-complement) or unsigned treatment of operands, the immediate and right shifts.

Top module: `rc_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator, all four register-file entries, `xl_valid_o` and `xl_data_o` become zero.
- R2: While `en` is low, the accumulator, the register file and `xl_data_o` keep their values, and `xl_valid_o` is 0 after the edge.
- R3: Context bits [31:28] select operand A: 0 north, 1 east, 2 south, 3 west (16-bit slices 0..3 of `nbr_i`), 4..6 row peers 0..2, 7..9 column peers 0..2, 10 operand bus, 11..14 register entries 0..3, 15 constant zero.
- R4: Context bits [27:25] select operand B: 0 north, 1 east, 2 south, 3 operand bus, 4..7 register entries 0..3.
- R5: Function code in bits [22:20] is 0 pass A, 1 A+B, 2 A−B, 3 A+immediate. Operands are sign-extended to 32 bits when `sgn_mode` is 1 and zero-extended otherwise. The 12-bit immediate in bits [11:0] is extended the same way.
- R6: Code 4 gives the 32-bit product A×B, signed when `sgn_mode` is 1 and unsigned otherwise.
- R7: Code 5 gives accumulator + A×B, so a multiply-accumulate completes in one cycle.
- R8: Code 7 gives the number of set bits in the 32-bit concatenation {A, B} (0 to 32).
- R9: Code 6 gives accumulator + |A−B|, with the difference taken on the extended operands.
- R10: The function result is shifted by bits [18:14] (0..31). When bit 19 is 0 the shift is left and logical. When bit 19 is 1 the shift is right: arithmetic if `sgn_mode` is 1, logical otherwise. The shifted value loads the accumulator every enabled cycle.
- R11: When bit 12 is set in an enabled cycle, the low 16 bits of the shifted value are written into register entry bits [24:23]. The other entries are unchanged.
- R12: When bit 13 is set in an enabled cycle, `xl_data_o` takes the low 16 bits of the shifted value and `xl_valid_o` is 1 after that edge. Otherwise `xl_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Execute the context this cycle |
| sgn_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| ctx_i | input | 32 | Context word for this cycle |
| nbr_i | input | 64 | Neighbour data: N, E, S, W in slices 0..3 |
| row_peer_i | input | 48 | Three same-row quadrant peers |
| col_peer_i | input | 48 | Three same-column quadrant peers |
| opbus_i | input | 16 | Operand-bus segment |
| acc_o | output | 32 | Accumulator / output register |
| xl_valid_o | output | 1 | Express-lane data valid |
| xl_data_o | output | 16 | Express-lane data |

## Verification
The embedded assertions check four things on every cycle: the disabled-cycle hold of the accumulator, the express-lane strobe rule, the register-file entries holding when nothing writes them, and the ones-count bound when no shift is applied. Only the bench's scenarios can show that each selector code reaches the right source and that the arithmetic results are correct. This covers signed and unsigned products at the extremes, accumulation across cycles, arithmetic versus logical right shifts and register write-back read again through operand A.

// File: rtl/rc_pkg.sv
// Package: shared context layout and function codes for the processing cell.
// Assumes a 32-bit context word with the packed order below (MSB first).
package rc_pkg;
    localparam int DW    = 16;
    localparam int ACC_W = 2 * DW;
    localparam int IMM_W = 12;
    localparam int SH_W  = 5;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_ADDI = 3'd3,
        OP_MUL  = 3'd4,
        OP_MAC  = 3'd5,
        OP_SAD  = 3'd6,
        OP_ONES = 3'd7
    } rc_op_e;

    typedef struct packed {
        logic [3:0]       sel_a;   // [31:28]
        logic [2:0]       sel_b;   // [27:25]
        logic [1:0]       rf_idx;  // [24:23]
        rc_op_e           op;      // [22:20]
        logic             shr;     // [19]
        logic [SH_W-1:0]  shamt;   // [18:14]
        logic             xl_en;   // [13]
        logic             rf_we;   // [12]
        logic [IMM_W-1:0] imm;     // [11:0]
    } rc_ctx_t;
endpackage

// File: rtl/rc_opsel.sv
// Operand selectors: picks operand A and operand B from neighbours, quadrant
// peers, the operand bus and the register file. Purely combinational.
// Assumes 4 + 2*NPEER + 1 + NREG <= 16 codes for A.
module rc_opsel #(
    parameter int DW    = 16,
    parameter int NPEER = 3,
    parameter int NREG  = 4
) (
    input  logic [4*DW-1:0]     nbr_i,
    input  logic [NPEER*DW-1:0] row_i,
    input  logic [NPEER*DW-1:0] col_i,
    input  logic [DW-1:0]       bus_i,
    input  logic [NREG*DW-1:0]  rf_i,
    input  logic [3:0]          sel_a,
    input  logic [2:0]          sel_b,
    output logic [DW-1:0]       op_a,
    output logic [DW-1:0]       op_b
);
    localparam int A_ROW = 4;
    localparam int A_COL = A_ROW + NPEER;
    localparam int A_BUS = A_COL + NPEER;
    localparam int A_RF  = A_BUS + 1;
    localparam int A_END = A_RF + NREG;
    localparam int B_BUS = 3;
    localparam int B_RF  = 4;

    // Operand A source decode
    always_comb begin
        int s;
        s = int'(sel_a);
        op_a = '0;
        if (s < A_ROW)      op_a = nbr_i[s*DW +: DW];
        else if (s < A_COL) op_a = row_i[(s-A_ROW)*DW +: DW];
        else if (s < A_BUS) op_a = col_i[(s-A_COL)*DW +: DW];
        else if (s == A_BUS) op_a = bus_i;
        else if (s < A_END) op_a = rf_i[(s-A_RF)*DW +: DW];
    end

    // Operand B source decode (three neighbours, bus, register file)
    always_comb begin
        int s;
        s = int'(sel_b);
        op_b = '0;
        if (s < B_BUS)       op_b = nbr_i[s*DW +: DW];
        else if (s == B_BUS) op_b = bus_i;
        else if (s - B_RF < NREG) op_b = rf_i[(s-B_RF)*DW +: DW];
    end
endmodule

// File: rtl/rc_alu.sv
// Function unit: arithmetic, multiply, multiply-accumulate, absolute
// difference accumulate and ones count on two DW-bit operands, producing a
// 2*DW-bit result. Combinational; accumulator value arrives as feedback.
module rc_alu
    import rc_pkg::*;
#(
    parameter int W   = 16,
    parameter int IW  = 12
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [IW-1:0]  imm,
    input  logic [2*W-1:0] acc,
    input  rc_op_e         op,
    input  logic           sgn,
    output logic [2*W-1:0] res
);
    localparam int RW = 2 * W;

    logic [RW-1:0]        a_x, b_x, i_x, diff, absd, prod;
    logic signed [W:0]    a_m, b_m;
    logic signed [RW-1:0] prod_s;

    // Operand and immediate extension per signed mode
    always_comb begin
        a_x = sgn ? {{W{a[W-1]}}, a}          : {{W{1'b0}}, a};
        b_x = sgn ? {{W{b[W-1]}}, b}          : {{W{1'b0}}, b};
        i_x = sgn ? {{(RW-IW){imm[IW-1]}}, imm} : {{(RW-IW){1'b0}}, imm};
    end

    // Multiplier: one extra top bit makes signed and unsigned share one array
    assign a_m    = $signed({sgn & a[W-1], a});
    assign b_m    = $signed({sgn & b[W-1], b});
    assign prod_s = a_m * b_m;
    assign prod   = prod_s;

    // Absolute difference of extended operands
    always_comb begin
        diff = a_x - b_x;
        absd = diff[RW-1] ? (~diff + 1'b1) : diff;
    end

    // Function select
    always_comb begin
        unique case (op)
            OP_PASS: res = a_x;
            OP_ADD:  res = a_x + b_x;
            OP_SUB:  res = a_x - b_x;
            OP_ADDI: res = a_x + i_x;
            OP_MUL:  res = prod;
            OP_MAC:  res = acc + prod;
            OP_SAD:  res = acc + absd;
            OP_ONES: res = RW'($countones({a, b}));
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/rc_shift.sv
// Barrel shifter on the function result: left logical, or right arithmetic
// or logical depending on signed mode. Combinational.
module rc_shift #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  d,
    input  logic          shr,
    input  logic          sgn,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  q
);
    // Direction and fill select
    always_comb begin
        if (!shr)     q = d << amt;
        else if (sgn) q = W'($signed(d) >>> amt);
        else          q = d >> amt;
    end
endmodule

// File: rtl/rc_regfile.sv
// Local register file: NREG entries of DW bits, one write port, all entries
// visible in parallel to the operand selectors. Synchronous active-low reset.
module rc_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IW-1:0]      idx,
    input  logic [DW-1:0]      d,
    output logic [NREG*DW-1:0] rf_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic [DW-1:0] r;
        // Entry i loads when selected by the write index
        always_ff @(posedge clk) begin
            if (!rst_n)                      r <= '0;
            else if (we && idx == IW'(i))    r <= d;
        end
        assign rf_o[i*DW +: DW] = r;
    end

    // R11: no entry changes without a write
    p_rf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rf_o));
endmodule

// File: rtl/rc_cell.sv
// Processing cell top: decodes the context word, selects operands, runs the
// function unit and shifter, and updates accumulator, register file and
// express lane. Assumes the context is valid in the cycle en is high.
module rc_cell
    import rc_pkg::*;
#(
    parameter int NPEER = 3,
    parameter int NREG  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                sgn_mode,
    input  logic [31:0]         ctx_i,
    input  logic [4*DW-1:0]     nbr_i,
    input  logic [NPEER*DW-1:0] row_peer_i,
    input  logic [NPEER*DW-1:0] col_peer_i,
    input  logic [DW-1:0]       opbus_i,
    output logic [ACC_W-1:0]    acc_o,
    output logic                xl_valid_o,
    output logic [DW-1:0]       xl_data_o
);
    rc_ctx_t            ctx;
    logic [DW-1:0]      op_a, op_b;
    logic [ACC_W-1:0]   fn_res, sh_res, acc_q;
    logic [NREG*DW-1:0] rf_w;
    logic               xl_v_q;
    logic [DW-1:0]      xl_d_q;

    assign ctx = rc_ctx_t'(ctx_i);

    rc_opsel #(.DW(DW), .NPEER(NPEER), .NREG(NREG)) u_sel (
        .nbr_i (nbr_i),
        .row_i (row_peer_i),
        .col_i (col_peer_i),
        .bus_i (opbus_i),
        .rf_i  (rf_w),
        .sel_a (ctx.sel_a),
        .sel_b (ctx.sel_b),
        .op_a  (op_a),
        .op_b  (op_b)
    );

    rc_alu #(.W(DW), .IW(IMM_W)) u_alu (
        .a   (op_a),
        .b   (op_b),
        .imm (ctx.imm),
        .acc (acc_q),
        .op  (ctx.op),
        .sgn (sgn_mode),
        .res (fn_res)
    );

    rc_shift #(.W(ACC_W), .SW(SH_W)) u_sh (
        .d   (fn_res),
        .shr (ctx.shr),
        .sgn (sgn_mode),
        .amt (ctx.shamt),
        .q   (sh_res)
    );

    rc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (en & ctx.rf_we),
        .idx   (ctx.rf_idx),
        .d     (sh_res[DW-1:0]),
        .rf_o  (rf_w)
    );

    // Accumulator loads the shifted result every enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= sh_res;
    end

    // Express lane: data captured and strobed when routed there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_v_q <= 1'b0;
            xl_d_q <= '0;
        end else begin
            xl_v_q <= en & ctx.xl_en;
            if (en && ctx.xl_en) xl_d_q <= sh_res[DW-1:0];
        end
    end

    assign acc_o      = acc_q;
    assign xl_valid_o = xl_v_q;
    assign xl_data_o  = xl_d_q;

    // R2: disabled cycle keeps the accumulator
    p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_o));
    // R12: routing to the express lane raises the strobe next cycle
    p_xl_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctx_i[13]) |=> xl_valid_o);
    // R12: no strobe and no data change without routing
    p_xl_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && ctx_i[13]) |=> (!xl_valid_o && $stable(xl_data_o)));
    // R8: unshifted ones count never exceeds the operand width
    p_ones_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctx_i[22:20] == 3'd7 && ctx_i[18:14] == 5'd0) |=> (acc_o <= 32'd32));
endmodule

// File: tb/tb_rc_cell.sv
// Bench for the processing cell: directed corners and seeded random contexts,
// checked against a behavioural model built from the requirements.
module tb_rc_cell;
    logic         clk = 1'b0;
    logic         rst_n, en, sgn;
    logic [31:0]  ctx;
    logic [63:0]  nbr;
    logic [47:0]  rowp, colp;
    logic [15:0]  bus;
    logic [31:0]  acc_o;
    logic         xl_valid_o;
    logic [15:0]  xl_data_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_acc;
    logic [15:0] m_rf [4];
    logic        m_xlv;
    logic [15:0] m_xld;

    always #10 clk = ~clk;

    rc_cell dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sgn_mode(sgn), .ctx_i(ctx),
        .nbr_i(nbr), .row_peer_i(rowp), .col_peer_i(colp), .opbus_i(bus),
        .acc_o(acc_o), .xl_valid_o(xl_valid_o), .xl_data_o(xl_data_o)
    );

    function automatic logic [31:0] mk(input logic [3:0] sa, input logic [2:0] sb,
                                       input logic [1:0] ri, input logic [2:0] op,
                                       input logic shr, input logic [4:0] amt,
                                       input logic xl, input logic we,
                                       input logic [11:0] imm);
        return {sa, sb, ri, op, shr, amt, xl, we, imm};
    endfunction

    function automatic logic [15:0] src_a(input logic [3:0] s);
        int i = int'(s);
        if (i <= 3)  return nbr[i*16 +: 16];
        if (i <= 6)  return rowp[(i-4)*16 +: 16];
        if (i <= 9)  return colp[(i-7)*16 +: 16];
        if (i == 10) return bus;
        if (i <= 14) return m_rf[i-11];
        return 16'h0;
    endfunction

    function automatic logic [15:0] src_b(input logic [2:0] s);
        int i = int'(s);
        if (i <= 2) return nbr[i*16 +: 16];
        if (i == 3) return bus;
        return m_rf[i-4];
    endfunction

    function automatic logic [31:0] ext16(input logic [15:0] v, input logic s);
        return s ? {{16{v[15]}}, v} : {16'h0, v};
    endfunction

    function automatic logic [31:0] model_res(input logic [31:0] c);
        logic [31:0] a, b, im, r, d;
        longint pa, pb;
        a  = ext16(src_a(c[31:28]), sgn);
        b  = ext16(src_b(c[27:25]), sgn);
        im = sgn ? {{20{c[11]}}, c[11:0]} : {20'h0, c[11:0]};
        pa = sgn ? longint'($signed(a)) : longint'(a);
        pb = sgn ? longint'($signed(b)) : longint'(b);
        case (c[22:20])
            3'd0: r = a;
            3'd1: r = a + b;
            3'd2: r = a - b;
            3'd3: r = a + im;
            3'd4: r = 32'(pa * pb);
            3'd5: r = m_acc + 32'(pa * pb);
            3'd6: begin d = a - b; r = m_acc + ($signed(d) < 0 ? -d : d); end
            default: r = 32'($countones({a[15:0], b[15:0]}));
        endcase
        if (!c[19])  return r << c[18:14];
        if (sgn)     return 32'($signed(r) >>> c[18:14]);
        return r >> c[18:14];
    endfunction

    function automatic string op_tag(input logic [31:0] c);
        case (c[22:20])
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R9";
            3'd7: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock with current inputs; model advanced, outputs compared
    task automatic step(input string tag);
        logic [31:0] r;
        r = model_res(ctx);
        @(posedge clk);
        if (!rst_n) begin
            m_acc = 0; m_xlv = 0; m_xld = 0;
            foreach (m_rf[i]) m_rf[i] = 0;
        end else if (en) begin
            m_acc = r;
            if (ctx[12]) m_rf[ctx[24:23]] = r[15:0];
            m_xlv = ctx[13];
            if (ctx[13]) m_xld = r[15:0];
        end else m_xlv = 0;
        @(negedge clk);
        chk(tag, acc_o, m_acc);
        chk({tag, " xl_valid (R12)"}, {31'h0, xl_valid_o}, {31'h0, m_xlv});
        chk({tag, " xl_data (R12)"}, {16'h0, xl_data_o}, {16'h0, m_xld});
    endtask

    task automatic rand_inputs();
        nbr  = {$urandom, $urandom};
        rowp = {16'($urandom), $urandom};
        colp = {16'($urandom), $urandom};
        bus  = 16'($urandom);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; en = 0; sgn = 0; ctx = 0;
        rand_inputs();
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;

        // R3: every operand A code, pass function, no shift
        for (int s = 0; s < 16; s++) begin
            en = 1; ctx = mk(4'(s), 0, 0, 3'd0, 0, 0, 0, 0, 0);
            step("R3 operand A select");
        end
        // R11: fill register file, then read each entry back through A
        for (int i = 0; i < 4; i++) begin
            bus = 16'hA500 + 16'(i);
            ctx = mk(4'd10, 0, 2'(i), 3'd0, 0, 0, 0, 1, 0);
            step("R11 write");
        end
        for (int i = 0; i < 4; i++) begin
            ctx = mk(4'(11 + i), 0, 0, 3'd0, 0, 0, 0, 0, 0);
            step("R11 readback");
            chk("R11 entry value", acc_o, 32'h0000A500 + 32'(i));
        end
        // R4: every operand B code added to zero A
        for (int s = 0; s < 8; s++) begin
            ctx = mk(4'd15, 3'(s), 0, 3'd1, 0, 0, 0, 0, 0);
            step("R4 operand B select");
        end
        // R6: product extremes
        sgn = 1; bus = 16'h8000;
        ctx = mk(4'd10, 3'd3, 0, 3'd4, 0, 0, 0, 0, 0);
        step("R6 signed multiply");
        chk("R6 signed min*min", acc_o, 32'h40000000);
        sgn = 0; bus = 16'hFFFF;
        step("R6 unsigned multiply");
        chk("R6 unsigned max*max", acc_o, 32'hFFFE0001);
        // R7: two back-to-back accumulations
        bus = 16'd3;
        ctx = mk(4'd10, 3'd3, 0, 3'd4, 0, 0, 0, 0, 0);
        step("R7 seed");
        ctx = mk(4'd10, 3'd3, 0, 3'd5, 0, 0, 0, 0, 0);
        step("R7 mac");
        step("R7 mac");
        chk("R7 9+9+9", acc_o, 32'd27);
        // R8: all ones count
        bus = 16'hFFFF;
        ctx = mk(4'd10, 3'd3, 0, 3'd7, 0, 0, 0, 0, 0);
        step("R8 ones");
        chk("R8 full count", acc_o, 32'd32);
        // R5: signed immediate extension
        sgn = 1; bus = 16'd5;
        ctx = mk(4'd10, 0, 0, 3'd3, 0, 0, 0, 0, 12'hFFE);
        step("R5 addi signed");
        chk("R5 5 + (-2)", acc_o, 32'd3);
        sgn = 0;
        step("R5 addi unsigned");
        chk("R5 5 + 4094", acc_o, 32'd4099);
        // R9: absolute difference accumulate
        sgn = 1; bus = 16'hFFF0; nbr[15:0] = 16'd4;
        ctx = mk(4'd15, 0, 0, 3'd0, 0, 0, 0, 0, 0);
        step("R9 clear");
        ctx = mk(4'd10, 3'd0, 0, 3'd6, 0, 0, 0, 0, 0);
        step("R9 sad");
        step("R9 sad");
        chk("R9 |-16-4|*2", acc_o, 32'd40);
        // R10: right shifts in both modes, left by 31
        bus = 16'h8000;
        ctx = mk(4'd10, 0, 0, 3'd0, 1, 5'd4, 0, 0, 0);
        step("R10 arith right");
        chk("R10 arith right", acc_o, 32'hFFFFF800);
        sgn = 0;
        step("R10 logical right");
        chk("R10 logical right", acc_o, 32'h00000800);
        bus = 16'h0001;
        ctx = mk(4'd10, 0, 0, 3'd0, 0, 5'd31, 1, 0, 0);
        step("R10 left 31");
        chk("R10 left 31", acc_o, 32'h80000000);
        // R12: lane data and strobe, then quiet cycle
        bus = 16'h1234;
        ctx = mk(4'd10, 0, 0, 3'd0, 0, 0, 1, 0, 0);
        step("R12 express lane");
        chk("R12 lane data", {16'h0, xl_data_o}, 32'h1234);
        ctx = mk(4'd10, 0, 0, 3'd0, 0, 0, 0, 0, 0);
        step("R12 lane quiet");
        // R2: disabled cycles with writes requested change nothing
        en = 0;
        for (int k = 0; k < 8; k++) begin
            rand_inputs(); ctx = $urandom | 32'h3000;
            step("R2 disabled");
        end
        en = 1;
        // Random contexts and data
        for (int k = 0; k < 3000; k++) begin
            rand_inputs();
            ctx = $urandom;
            en  = ($urandom % 8) != 0;
            sgn = 1'($urandom);
            step(en ? op_tag(ctx) : "R2");
        end
        // R1: reset after activity clears register file too
        rst_n = 0;
        step("R1 reset late");
        rst_n = 1; en = 1; sgn = 0;
        for (int i = 0; i < 4; i++) begin
            ctx = mk(4'(11 + i), 0, 0, 3'd0, 0, 0, 0, 0, 0);
            step("R1 register cleared");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule